// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a clocked host read and write an external 32,768 x 8 asynchronous static RAM. The host presents an address, write data and a read/write flag under a valid/ready handshake. The controller then runs the memory's strobes and address and data lines for one access. It returns read data with a single-cycle valid pulse.

Each memory timing minimum is turned into a whole number of clock cycles at elaboration. The inputs are the clock period in picoseconds and a speed-grade index:

| Index | Access time |
|---|---|
| 0 | 7 ns |
| 1 | 8 ns |
| 2 | 10 ns |

Writes normally hold output enable inactive, so the shorter write strobe can be used. A parameter selects the other mode, where output enable stays active during writes. In that mode the strobe is longer and the data driver waits for the memory to release the bus. The controller never drives the data bus while the memory may be driving it. It inserts a turnaround gap between a read and a following write.

Top module: `sram_ctl_top`

## Requirements
- R1: While reset is asserted and right after it, chip enable, write enable and output enable are high (inactive), the data driver is off, ready is high and read-data-valid is low.
- R2: With output enable held high for writes (default), every write keeps write enable low for at least ceil(max(write pulse, chip-enable-to-end-of-write)/clock) cycles, which is 2 cycles at 5 ns and the 10 ns grade. Output enable stays high for the whole strobe, and the driver carries the write data in the strobe's last cycle.
- R3: A read holds chip enable low, output enable low and write enable high for ceil(access time/clock) cycles, which is 2 at the defaults. The data bus is sampled on the edge that ends this window. Read-data-valid is high for exactly the one cycle after that edge, carrying the last value written to that address.
- R4: The data driver is never on while the memory may be driving. That is any cycle with chip enable and output enable low, and either write enable high or write enable low for fewer than ceil(5 ns/clock) cycles.
- R5: Between the last cycle in which the memory is in read-drive state and the first cycle of data driving, at least one whole clock cycle passes.
- R6: Ready is high only in the idle state, and a request is taken on a clock edge where valid and ready are both high. Ready is low in the cycle after acceptance. In idle all three strobes are high and the driver is off.
- R7: The memory address does not change while chip enable stays low.
- R8: Write data on the bus does not change while the driver is on.
- R9: Write requests produce no read-data-valid pulse.
- R10: With output enable kept low for writes, output enable stays low through the strobe. The strobe lasts at least ceil(10 ns/clock) cycles and at least the release cycles plus the data-setup cycles. The driver stays off for the first ceil(5 ns/clock) strobe cycles.
- R11: All 15 address bits reach the memory, so locations 0x0000 and 0x7FFF hold independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request can be accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle pulse, read data valid |
| rd_data_o | output | 8 | Read data |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the data tri-state driver |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The bench writes and reads back at address zero, at the top address and with alternating bit patterns, and overwrites a location to separate stored data from stale bus values. Reads that directly follow writes, and writes that directly follow reads, probe the turnaround gap and the single-cycle valid pulse. Two instances are driven in lockstep: one holds output enable high during writes and the other keeps it low. Each is connected to a memory model that flags contention, address or data movement, and short strobes. This separates the two strobe and driver schedules.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WSTB,
    ST_RACC
  } st_e;

  // grade: 0 fastest, 1 middle, 2 slowest
  function automatic int pick_ps(input int grade, input int g0, input int g1, input int g2);
    if (grade == 0) return g0;
    if (grade == 1) return g1;
    return g2;
  endfunction

  // round up to whole clock cycles, never below one
  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int WP_CYC = 2,
  parameter int RD_CYC = 2,
  parameter int TA_CYC = 1,
  parameter int CNT_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             cap_o,
  output st_e              state_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] WP_L = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_L = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_L = CNT_W'(TA_CYC - 1);

  st_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last_rd_q;
  logic             last;

  always_comb begin
    accept_o = req_valid_i && (state_q == ST_IDLE);
    case (state_q)
      ST_TURN: last = (cnt_q == TA_L);
      ST_WSTB: last = (cnt_q == WP_L);
      ST_RACC: last = (cnt_q == RD_L);
      default: last = 1'b1;
    endcase
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_o) state_d = req_we_i ? (last_rd_q ? ST_TURN : ST_WSET) : ST_RACC;
      ST_TURN: if (last) state_d = ST_WSET;
      ST_WSET: state_d = ST_WSTB;
      ST_WSTB: if (last) state_d = ST_IDLE;
      ST_RACC: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
      if (accept_o) last_rd_q <= !req_we_i;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign cap_o   = (state_q == ST_RACC) && last;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  p_busy_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int AW            = 15,
  parameter int DW            = 8,
  parameter int CNT_W         = 2,
  parameter int HZ_CYC        = 0,
  parameter bit OE_HIGH_WRITE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             cap_i,
  input  st_e              state_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [DW-1:0]    mem_dq_i,
  output logic             mem_ce_n_o,
  output logic             mem_we_n_o,
  output logic             mem_oe_n_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;
  logic          in_write;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (cap_i) rdata_q <= mem_dq_i;
      rvalid_q <= cap_i;
    end
  end

  assign in_write    = (state_i == ST_WSET) || (state_i == ST_WSTB);
  assign mem_ce_n_o  = !(in_write || (state_i == ST_RACC));
  assign mem_we_n_o  = (state_i != ST_WSTB);
  // driver waits out the memory's release window when OE stays low
  assign mem_dq_oe_o = (state_i == ST_WSTB) && (int'(cnt_i) >= HZ_CYC);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rd_valid_o  = rvalid_q;
  assign rd_data_o   = rdata_q;

  generate
    if (OE_HIGH_WRITE) begin : g_oe_high
      assign mem_oe_n_o = (state_i != ST_RACC);
    end else begin : g_oe_low
      assign mem_oe_n_o = !(in_write || (state_i == ST_RACC));
    end
  endgenerate

  p_rvalid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_no_contend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o) |-> !mem_dq_oe_o);

  p_turn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_ce_n_o || mem_oe_n_o || !mem_we_n_o));

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

  p_data_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

endmodule

// File: rtl/sram_ctl_top.sv
module sram_ctl_top
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PS        = 5000,
  parameter int GRADE         = 2,
  parameter bit OE_HIGH_WRITE = 1'b1,
  parameter int AW            = 15,
  parameter int DW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int WP_PS   = OE_HIGH_WRITE ? pick_ps(GRADE, 5000, 6000, 7000)
                                         : pick_ps(GRADE, 7000, 8000, 10000);
  localparam int CW_PS   = pick_ps(GRADE, 5000, 6000, 7000);
  localparam int RD_PS   = pick_ps(GRADE, 7000, 8000, 10000);
  localparam int HZOE_PS = pick_ps(GRADE, 4000, 5000, 5000);
  localparam int DS_CYC  = ps_to_cyc(5000, CLK_PS);
  localparam int HZ_CYC  = OE_HIGH_WRITE ? 0 : ps_to_cyc(5000, CLK_PS);
  localparam int WP_CYC  = imax(imax(ps_to_cyc(WP_PS, CLK_PS), ps_to_cyc(CW_PS, CLK_PS)),
                                HZ_CYC + DS_CYC);
  localparam int RD_CYC  = ps_to_cyc(RD_PS, CLK_PS);
  localparam int TA_CYC  = ps_to_cyc(HZOE_PS, CLK_PS);
  localparam int MAX_CYC = imax(imax(WP_CYC, RD_CYC), TA_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  st_e              state;
  logic [CNT_W-1:0] cnt;
  logic             accept, cap;

  sram_ctl_fsm #(
    .WP_CYC(WP_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .cap_o      (cap),
    .state_o    (state),
    .cnt_o      (cnt)
  );

  sram_ctl_pins #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .HZ_CYC(HZ_CYC), .OE_HIGH_WRITE(OE_HIGH_WRITE)
  ) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .cap_i      (cap),
    .state_i    (state),
    .cnt_i      (cnt),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: tb/sram_ctl_top_tb_top.sv
`timescale 1ns/1ps

module sram_mem_model #(
  parameter int HZ_SAMPLES = 1
) (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [14:0] addr,
  input  logic [7:0]  dq_from_ctl,
  input  logic        dq_oe,
  output logic [7:0]  dq_to_ctl,
  output int          contend_o,
  output int          addr_err_o,
  output int          data_err_o,
  output int          turn_err_o,
  output int          min_stb_o,
  output int          oe_lo_stb_o
);
  logic [7:0] mem [int unsigned];
  int contend = 0, addr_err = 0, data_err = 0, turn_err = 0;
  int min_stb = 1000, oe_lo_stb = 0, we_lo = 0, cyc = 0, last_rd_cyc = -10;
  logic [14:0] prev_addr = '0, pend_a = '0;
  logic [7:0]  prev_dq = '0, pend_d = '0;
  logic prev_ce_lo = 1'b0, prev_drv = 1'b0, pend_v = 1'b0, last_drv = 1'b0;
  logic mem_drives;

  initial dq_to_ctl = 8'hA5;

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_drives = !ce_n && !oe_n && (we_n || we_lo < HZ_SAMPLES);
    if (dq_oe && mem_drives) contend = contend + 1;
    if (!ce_n && prev_ce_lo && addr != prev_addr) addr_err = addr_err + 1;
    if (dq_oe && prev_drv && dq_from_ctl != prev_dq) data_err = data_err + 1;
    if (dq_oe && !prev_drv && (cyc - last_rd_cyc) < 2) turn_err = turn_err + 1;
    if (!ce_n && !we_n) begin
      if (!oe_n) oe_lo_stb = oe_lo_stb + 1;
      if (dq_oe) begin pend_a = addr; pend_d = dq_from_ctl; pend_v = 1'b1; end
      last_drv = dq_oe;
      we_lo = we_lo + 1;
    end else begin
      if (we_lo > 0) begin
        if (we_lo < min_stb) min_stb = we_lo;
        if (!last_drv) data_err = data_err + 1;
        if (pend_v) mem[int'(pend_a)] = pend_d;
        pend_v = 1'b0;
      end
      we_lo = 0;
    end
    if (!ce_n && !oe_n && we_n) last_rd_cyc = cyc;
    if (!ce_n && we_n && !oe_n)
      dq_to_ctl = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
    else
      dq_to_ctl = 8'hA5;
    prev_addr = addr; prev_ce_lo = !ce_n; prev_dq = dq_from_ctl; prev_drv = dq_oe;
  end

  assign contend_o   = contend;
  assign addr_err_o  = addr_err;
  assign data_err_o  = data_err;
  assign turn_err_o  = turn_err;
  assign min_stb_o   = min_stb;
  assign oe_lo_stb_o = oe_lo_stb;
endmodule

module sram_ctl_top_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic        rdy0, rv0, ce0, wen0, oen0, doe0;
  logic [7:0]  rd0, dqo0, dqi0;
  logic [14:0] ma0;
  logic        rdy1, rv1, ce1, wen1, oen1, doe1;
  logic [7:0]  rd1, dqo1, dqi1;
  logic [14:0] ma1;
  int cont0, aerr0, derr0, terr0, mstb0, oelo0;
  int cont1, aerr1, derr1, terr1, mstb1, oelo1;

  sram_ctl_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(rdy0),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rd_valid_o(rv0), .rd_data_o(rd0), .mem_ce_n_o(ce0), .mem_we_n_o(wen0),
    .mem_oe_n_o(oen0), .mem_addr_o(ma0), .mem_dq_o(dqo0), .mem_dq_oe_o(doe0),
    .mem_dq_i(dqi0));

  sram_ctl_top #(.OE_HIGH_WRITE(1'b0)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(rdy1),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rd_valid_o(rv1), .rd_data_o(rd1), .mem_ce_n_o(ce1), .mem_we_n_o(wen1),
    .mem_oe_n_o(oen1), .mem_addr_o(ma1), .mem_dq_o(dqo1), .mem_dq_oe_o(doe1),
    .mem_dq_i(dqi1));

  sram_mem_model m0 (.clk(clk), .ce_n(ce0), .we_n(wen0), .oe_n(oen0), .addr(ma0),
    .dq_from_ctl(dqo0), .dq_oe(doe0), .dq_to_ctl(dqi0), .contend_o(cont0),
    .addr_err_o(aerr0), .data_err_o(derr0), .turn_err_o(terr0),
    .min_stb_o(mstb0), .oe_lo_stb_o(oelo0));

  sram_mem_model m1 (.clk(clk), .ce_n(ce1), .we_n(wen1), .oe_n(oen1), .addr(ma1),
    .dq_from_ctl(dqo1), .dq_oe(doe1), .dq_to_ctl(dqi1), .contend_o(cont1),
    .addr_err_o(aerr1), .data_err_o(derr1), .turn_err_o(terr1),
    .min_stb_o(mstb1), .oe_lo_stb_o(oelo1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(ce0 && wen0 && oen0 && !doe0 && ce1 && wen1 && oen1 && !doe1, req,
        {ce0, wen0, oen0, doe0, ce1, wen1, oen1, doe1}, 8'hEE);
  endtask

  // one request through both controllers in lockstep
  task automatic op(input logic w, input logic [14:0] a, input logic [7:0] d,
                    output logic [7:0] q0, output logic [7:0] q1);
    q0 = '0; q1 = '0;
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    while (!rdy0) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    chk(!rdy0 && !rdy1, "R6 ready low during access", {rdy0, rdy1}, 0);
    if (!w) begin
      @(negedge clk);
      chk(!rv0 && !rv1, "R3 valid not before window end", {rv0, rv1}, 0);
      @(negedge clk);
      chk(rv0 && rv1, "R3 valid after window end", {rv0, rv1}, 3);
      q0 = rd0; q1 = rd1;
      @(negedge clk);
      chk(!rv0 && !rv1, "R3 valid lasts one cycle", {rv0, rv1}, 0);
    end else begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!rv0 && !rv1, "R9 no valid on write", {rv0, rv1}, 0);
      end
      chk_idle("R6 idle pins after write");
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_idle("R1 strobes high in reset");
    chk(rdy0 && rdy1 && !rv0 && !rv1, "R1 ready/valid in reset", {rdy0, rdy1, rv0, rv1}, 4'hC);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1 strobes high after reset");
    chk(rdy0 && !rv0, "R1 ready after reset", {rdy0, rv0}, 2);
  endtask

  task automatic t_basic;
    logic [7:0] q0, q1;
    op(1'b1, 15'h0000, 8'h3C, q0, q1);
    op(1'b0, 15'h0000, 8'h00, q0, q1);
    chk(q0 == 8'h3C, "R3 readback addr 0 oe-high", q0, 8'h3C);
    chk(q1 == 8'h3C, "R10 readback addr 0 oe-low", q1, 8'h3C);
  endtask

  task automatic t_boundary;
    logic [7:0] q0, q1;
    op(1'b1, 15'h7FFF, 8'hFF, q0, q1);
    op(1'b1, 15'h0001, 8'h11, q0, q1);
    op(1'b0, 15'h7FFF, 8'h00, q0, q1);
    chk(q0 == 8'hFF && q1 == 8'hFF, "R11 top address", {q0, q1}, 16'hFFFF);
    op(1'b0, 15'h0000, 8'h00, q0, q1);
    chk(q0 == 8'h3C && q1 == 8'h3C, "R11 addr 0 untouched", {q0, q1}, 16'h3C3C);
  endtask

  task automatic t_patterns;
    logic [7:0] q0, q1;
    op(1'b1, 15'h2AAA, 8'h55, q0, q1);
    op(1'b1, 15'h5555, 8'hAA, q0, q1);
    op(1'b0, 15'h2AAA, 8'h00, q0, q1);
    chk(q0 == 8'h55 && q1 == 8'h55, "R3 pattern 55", {q0, q1}, 16'h5555);
    op(1'b0, 15'h5555, 8'h00, q0, q1);
    chk(q0 == 8'hAA && q1 == 8'hAA, "R3 pattern AA", {q0, q1}, 16'hAAAA);
  endtask

  task automatic t_overwrite_turn;
    logic [7:0] q0, q1;
    // read immediately followed by write exercises turnaround
    op(1'b0, 15'h2AAA, 8'h00, q0, q1);
    op(1'b1, 15'h2AAA, 8'hC3, q0, q1);
    op(1'b0, 15'h2AAA, 8'h00, q0, q1);
    chk(q0 == 8'hC3 && q1 == 8'hC3, "R3 overwrite visible", {q0, q1}, 16'hC3C3);
    chk(terr0 == 0 && terr1 == 0, "R5 read-to-write gap", terr0 + terr1, 0);
  endtask

  task automatic t_final;
    chk(cont0 == 0 && cont1 == 0, "R4 no bus contention", cont0 + cont1, 0);
    chk(mstb0 >= 2, "R2 strobe width oe-high", mstb0, 2);
    chk(oelo0 == 0, "R2 oe high during strobe", oelo0, 0);
    chk(mstb1 >= 2, "R10 strobe width oe-low", mstb1, 2);
    chk(oelo1 > 0, "R10 oe low during strobe", oelo1, 1);
    chk(aerr0 == 0 && aerr1 == 0, "R7 address stable", aerr0 + aerr1, 0);
    chk(derr0 == 0 && derr1 == 0, "R8 data stable and driven", derr0 + derr1, 0);
    chk(terr0 == 0 && terr1 == 0, "R5 turnaround final", terr0 + terr1, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_boundary();
    t_patterns();
    t_overwrite_turn();
    repeat (3) @(negedge clk);
    t_final();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule